// File: doc/BRIEF.md
# Video Controller CPU Register Port with Warmup Lockout

This block is the processor-facing register file of a tile-based video controller. The processor sees eight byte-wide offsets. Through them it reaches:

- the control and mask bytes;
- a two-write sequencer for the scroll and address ports, which builds a 15-bit staging address and a 3-bit fine horizontal scroll;
- the live video-memory address;
- the object-memory pointer;
- a one-byte read-ahead buffer for the data port.

Rendering, object storage and the external memories sit outside the block. The block only drives the address and strobes for them and takes their read bytes in.

A small warmup state machine follows reset. It has two states. `WU_ACTIVE` is entered on power-on or reset. `WU_DONE` is entered from `WU_ACTIVE` when the frame timing pulses `vbl_end` (the end-of-vertical-blank strobe that also clears the status flags), and it is left only by another reset. While the machine is in `WU_ACTIVE`:

- the control, mask, staging address, fine scroll, write sequencer and read buffer are forced to zero;
- writes to the control, mask, scroll and address offsets are discarded;
- status, object pointer, object data and data-port accesses keep working.

The write sequencer is a second state machine. It moves from `PH_FIRST` to `PH_SECOND` on an accepted scroll or address write. It moves from `PH_SECOND` to `PH_FIRST` on the next such write or on a status read. It is forced to `PH_FIRST` while warming or in reset.

The block has two synchronous, active-low resets. `por_n` is the power-on input and clears everything, including the live address and the object pointer. `rst_n` is the reset input and leaves those two untouched.

Top module: `vid_cpu_regs`

## Requirements
- R1: While `por_n` is low, on the next clock every held value becomes zero: control, mask, staging address, fine scroll, live address (`vram_addr`), object pointer and read buffer. The sequencer returns to `PH_FIRST` and `warming` is 1.
- R2: While `rst_n` is low (with `por_n` high), control, mask, staging address, fine scroll, read buffer and sequencer are cleared and `warming` becomes 1. `vram_addr` and `obj_addr` keep their values.
- R3: `warming` falls on the clock after a cycle in which it is 1 and `vbl_end` is 1, and stays 0 until the next reset. A write presented in the same cycle as the `vbl_end` pulse is still discarded.
- R4: While `warming` is 1, writes to offsets 0, 1, 5 and 6 change nothing, and the sequencer stays in `PH_FIRST`.
- R5: While `warming` is 1, the following work as normal: offset 3 writes load `obj_addr`; offset 4 writes pulse `obj_we` and add 1 to `obj_addr`; offset 4 reads return `obj_rdata`; offset 7 writes pulse `vram_we`.
- R6: In `PH_FIRST`, an offset-5 write loads fine scroll from data[2:0] and staging[4:0] from data[7:3]. In `PH_SECOND`, it loads staging[14:12] from data[2:0] and staging[9:5] from data[7:3].
- R7: In `PH_FIRST`, an offset-6 write loads staging[13:8] from data[5:0] and clears staging[14]. In `PH_SECOND`, it loads staging[7:0] and copies the whole staging address into `vram_addr`.
- R8: An offset-2 read returns {`stat_flags`, 5'b00000} and returns the sequencer to `PH_FIRST`.
- R9: An offset-7 read returns the buffered byte and then loads the buffer from `vram_rdata`. While warming, the buffer stays zero.
- R10: Every offset-7 access outside reset adds 32 to `vram_addr` when control bit 2 is 1, and adds 1 otherwise.
- R11: When not warming, an offset-0 write loads control and copies data[1:0] into staging[11:10]. An offset-1 write loads mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on clear, active low, synchronous |
| rst_n | input | 1 | Reset, active low, synchronous |
| vbl_end | input | 1 | End-of-vertical-blank pulse from frame timing |
| cpu_sel | input | 1 | Register access this cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 3 | Register offset |
| cpu_wdata | input | 8 | Write byte |
| cpu_rdata | output | 8 | Read byte (combinational) |
| stat_flags | input | 3 | Status flags returned in bits 7:5 |
| obj_rdata | input | 8 | Object memory read byte |
| vram_rdata | input | 8 | Video memory byte at `vram_addr` |
| vram_addr | output | 15 | Live video-memory address |
| vram_we | output | 1 | Video memory write strobe |
| obj_we | output | 1 | Object memory write strobe |
| obj_addr | output | 8 | Object memory pointer |
| ctrl_q | output | 8 | Control byte |
| mask_q | output | 8 | Mask byte |
| tmp_addr | output | 15 | Staging address |
| fine_x | output | 3 | Fine horizontal scroll |
| wr_second | output | 1 | Sequencer is in `PH_SECOND` |
| warming | output | 1 | Warmup machine is in `WU_ACTIVE` |

## Verification
The hardest situation to reach is a reset taken after the block has left warmup and been loaded with non-zero values. Reset must then clear one group of registers and leave the live address and object pointer exactly where they were. The bench first releases warmup with a `vbl_end` pulse. It then writes control, mask and a half-finished scroll pair, and moves the live address and object pointer to values that cannot occur by chance. Only after that does it pulse `rst_n`. The same-cycle race between `vbl_end` and a blocked write is produced by presenting both on one clock.

// File: rtl/vid_regs_pkg.sv
package vid_regs_pkg;

    localparam int VA_W = 15;

    // Register offsets; the processor side decodes these, so the order is fixed.
    localparam logic [2:0] OFS_CTRL = 3'd0;
    localparam logic [2:0] OFS_MASK = 3'd1;
    localparam logic [2:0] OFS_STAT = 3'd2;
    localparam logic [2:0] OFS_OPTR = 3'd3;
    localparam logic [2:0] OFS_ODAT = 3'd4;
    localparam logic [2:0] OFS_SCRL = 3'd5;
    localparam logic [2:0] OFS_VADR = 3'd6;
    localparam logic [2:0] OFS_DATA = 3'd7;

    typedef enum logic {
        WU_DONE   = 1'b0,
        WU_ACTIVE = 1'b1
    } wu_state_t;

    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } wr_phase_t;

endpackage

// File: rtl/vid_warmup.sv
module vid_warmup
    import vid_regs_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic rst_n,
    input  logic vbl_end,
    output logic warming
);

    wu_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!por_n || !rst_n) state_q <= WU_ACTIVE;
        else                  state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WU_ACTIVE: if (vbl_end) state_d = WU_DONE;
            WU_DONE:   state_d = WU_DONE;
        endcase
    end

    assign warming = (state_q == WU_ACTIVE);

    // R3: the end-of-blank pulse releases the lockout on the following clock
    a_r3_release: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (warming && vbl_end) |=> !warming);

    // R3: once released, lockout stays off until a reset
    a_r3_stay_off: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        !warming |=> !warming);

endmodule

// File: rtl/vid_wr_toggle.sv
module vid_wr_toggle
    import vid_regs_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic rst_n,
    input  logic warming,
    input  logic flip,
    input  logic clr,
    output logic second
);

    wr_phase_t ph_q, ph_d;

    always_ff @(posedge clk) begin
        if (!por_n || !rst_n || warming) ph_q <= PH_FIRST;
        else                             ph_q <= ph_d;
    end

    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            PH_FIRST:  if (flip)        ph_d = PH_SECOND;
            PH_SECOND: if (flip || clr) ph_d = PH_FIRST;
        endcase
    end

    assign second = (ph_q == PH_SECOND);

    // R4: no toggling while locked out
    a_r4_toggle_held: assert property (@(posedge clk) disable iff (!por_n)
        warming |=> !second);

    // R8: a status read brings the sequencer back to its first phase
    a_r8_status_clears: assert property (@(posedge clk) disable iff (!por_n)
        (clr && rst_n) |=> !second);

endmodule

// File: rtl/vid_cpu_regs.sv
module vid_cpu_regs
    import vid_regs_pkg::*;
#(
    parameter int ROW_STEP    = 32,
    parameter int INC_SEL_BIT = 2
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             rst_n,
    input  logic             vbl_end,
    input  logic             cpu_sel,
    input  logic             cpu_we,
    input  logic [2:0]       cpu_addr,
    input  logic [7:0]       cpu_wdata,
    output logic [7:0]       cpu_rdata,
    input  logic [2:0]       stat_flags,
    input  logic [7:0]       obj_rdata,
    input  logic [7:0]       vram_rdata,
    output logic [VA_W-1:0]  vram_addr,
    output logic             vram_we,
    output logic             obj_we,
    output logic [7:0]       obj_addr,
    output logic [7:0]       ctrl_q,
    output logic [7:0]       mask_q,
    output logic [VA_W-1:0]  tmp_addr,
    output logic [2:0]       fine_x,
    output logic             wr_second,
    output logic             warming
);

    localparam int NUM_OFS = 8;

    logic [NUM_OFS-1:0] hit;
    logic               wr, rd, live, locked;
    logic               scroll_go, addr_go, data_go;
    logic [VA_W-1:0]    step_v, cur_q, tmp_q;
    logic [7:0]         ctrl_r, mask_r, optr_q, rbuf_q;
    logic [2:0]         fx_q;

    genvar g;
    generate
        for (g = 0; g < NUM_OFS; g++) begin : g_dec
            assign hit[g] = cpu_sel && (cpu_addr == 3'(g));
        end
    endgenerate

    assign wr        = cpu_sel && cpu_we;
    assign rd        = cpu_sel && !cpu_we;
    assign live      = por_n && rst_n;
    assign locked    = !live || warming;
    assign scroll_go = wr && hit[OFS_SCRL] && !locked;
    assign addr_go   = wr && hit[OFS_VADR] && !locked;
    assign data_go   = hit[OFS_DATA] && live;
    assign step_v    = ctrl_r[INC_SEL_BIT] ? VA_W'(ROW_STEP) : VA_W'(1);

    vid_warmup u_warm (
        .clk     (clk),
        .por_n   (por_n),
        .rst_n   (rst_n),
        .vbl_end (vbl_end),
        .warming (warming)
    );

    vid_wr_toggle u_tog (
        .clk     (clk),
        .por_n   (por_n),
        .rst_n   (rst_n),
        .warming (warming),
        .flip    (scroll_go || addr_go),
        .clr     (rd && hit[OFS_STAT]),
        .second  (wr_second)
    );

    // Control and mask: held clear during lockout
    always_ff @(posedge clk) begin
        if (locked) begin
            ctrl_r <= '0;
            mask_r <= '0;
        end else begin
            if (wr && hit[OFS_CTRL]) ctrl_r <= cpu_wdata;
            if (wr && hit[OFS_MASK]) mask_r <= cpu_wdata;
        end
    end

    // Staging address and fine scroll
    always_ff @(posedge clk) begin
        if (locked) begin
            tmp_q <= '0;
            fx_q  <= '0;
        end else if (wr && hit[OFS_CTRL]) begin
            tmp_q[11:10] <= cpu_wdata[1:0];
        end else if (scroll_go) begin
            if (!wr_second) begin
                fx_q       <= cpu_wdata[2:0];
                tmp_q[4:0] <= cpu_wdata[7:3];
            end else begin
                tmp_q[14:12] <= cpu_wdata[2:0];
                tmp_q[9:5]   <= cpu_wdata[7:3];
            end
        end else if (addr_go) begin
            if (!wr_second) begin
                tmp_q[14]   <= 1'b0;
                tmp_q[13:8] <= cpu_wdata[5:0];
            end else begin
                tmp_q[7:0]  <= cpu_wdata;
            end
        end
    end

    // Live address: only power-on clears it
    always_ff @(posedge clk) begin
        if (!por_n) begin
            cur_q <= '0;
        end else if (rst_n) begin
            if (addr_go && wr_second) cur_q <= {tmp_q[14:8], cpu_wdata};
            else if (data_go)         cur_q <= cur_q + step_v;
        end
    end

    // Object pointer: only power-on clears it
    always_ff @(posedge clk) begin
        if (!por_n) begin
            optr_q <= '0;
        end else if (rst_n) begin
            if (wr && hit[OFS_OPTR])      optr_q <= cpu_wdata;
            else if (wr && hit[OFS_ODAT]) optr_q <= optr_q + 8'd1;
        end
    end

    // Read-ahead buffer
    always_ff @(posedge clk) begin
        if (locked)                  rbuf_q <= '0;
        else if (rd && hit[OFS_DATA]) rbuf_q <= vram_rdata;
    end

    always_comb begin
        case (cpu_addr)
            OFS_STAT: cpu_rdata = {stat_flags, 5'b00000};
            OFS_ODAT: cpu_rdata = obj_rdata;
            OFS_DATA: cpu_rdata = rbuf_q;
            default:  cpu_rdata = 8'h00;
        endcase
    end

    assign vram_we   = wr && hit[OFS_DATA] && live;
    assign obj_we    = wr && hit[OFS_ODAT] && live;
    assign vram_addr = cur_q;
    assign obj_addr  = optr_q;
    assign ctrl_q    = ctrl_r;
    assign mask_q    = mask_r;
    assign tmp_addr  = tmp_q;
    assign fine_x    = fx_q;

    // R2: reset leaves the live address and object pointer alone
    a_r2_cur_kept: assert property (@(posedge clk) disable iff (!por_n)
        !rst_n |=> (vram_addr == $past(vram_addr)));
    a_r2_optr_kept: assert property (@(posedge clk) disable iff (!por_n)
        !rst_n |=> (obj_addr == $past(obj_addr)));

    // R4: lockout keeps the guarded registers at zero
    a_r4_held_clear: assert property (@(posedge clk) disable iff (!por_n)
        warming |=> (ctrl_q == 8'h00 && mask_q == 8'h00 && tmp_addr == '0 && fine_x == 3'd0));

    // R9: data-port reads during lockout see an empty buffer
    a_r9_buf_empty: assert property (@(posedge clk) disable iff (!por_n)
        (warming && rd && cpu_addr == OFS_DATA) |-> (cpu_rdata == 8'h00));

    // R10: every data access moves the live address by the selected step
    a_r10_step: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (cpu_sel && cpu_addr == OFS_DATA)
        |=> (vram_addr == $past(vram_addr) + (($past(ctrl_q) & 8'h04) != 0 ? VA_W'(32) : VA_W'(1))));

endmodule

// File: tb/sim_vid_cpu_regs.sv
module sim_vid_cpu_regs;

    logic        clk = 1'b0;
    logic        por_n = 1'b0, rst_n = 1'b1, vbl_end = 1'b0;
    logic        cpu_sel = 1'b0, cpu_we = 1'b0;
    logic [2:0]  cpu_addr = 3'd0;
    logic [7:0]  cpu_wdata = 8'h00;
    logic [7:0]  cpu_rdata;
    logic [2:0]  stat_flags = 3'b000;
    logic [7:0]  obj_rdata = 8'h00, vram_rdata = 8'h00;
    logic [14:0] vram_addr, tmp_addr;
    logic        vram_we, obj_we, wr_second, warming;
    logic [7:0]  obj_addr, ctrl_q, mask_q;
    logic [2:0]  fine_x;

    int checks = 0;
    int fails  = 0;
    logic seen_vram_we, seen_obj_we;
    logic [7:0] rval;

    always #2.5 clk = ~clk;

    vid_cpu_regs u0 (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .vbl_end(vbl_end),
        .cpu_sel(cpu_sel), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .stat_flags(stat_flags),
        .obj_rdata(obj_rdata), .vram_rdata(vram_rdata), .vram_addr(vram_addr),
        .vram_we(vram_we), .obj_we(obj_we), .obj_addr(obj_addr),
        .ctrl_q(ctrl_q), .mask_q(mask_q), .tmp_addr(tmp_addr),
        .fine_x(fine_x), .wr_second(wr_second), .warming(warming)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_sel = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        #1;
        seen_vram_we = vram_we;
        seen_obj_we  = obj_we;
        @(negedge clk);
        cpu_sel = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic cpu_read(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        cpu_sel = 1'b1; cpu_we = 1'b0; cpu_addr = a;
        #1;
        v = cpu_rdata;
        @(negedge clk);
        cpu_sel = 1'b0;
    endtask

    task automatic t_power_on;
        @(negedge clk); por_n = 1'b0;
        repeat (2) @(negedge clk);
        por_n = 1'b1;
        chk("R1 ctrl", 16'(ctrl_q), 16'h0);
        chk("R1 mask", 16'(mask_q), 16'h0);
        chk("R1 tmp", 16'(tmp_addr), 16'h0);
        chk("R1 finex", 16'(fine_x), 16'h0);
        chk("R1 cur", 16'(vram_addr), 16'h0);
        chk("R1 optr", 16'(obj_addr), 16'h0);
        chk("R1 phase", 16'(wr_second), 16'h0);
        chk("R1 warming", 16'(warming), 16'h1);
    endtask

    task automatic t_warm_blocked;
        cpu_write(3'd0, 8'hFF);
        cpu_write(3'd1, 8'hFF);
        cpu_write(3'd5, 8'hFF);
        cpu_write(3'd6, 8'hFF);
        cpu_write(3'd6, 8'h77);
        chk("R4 ctrl", 16'(ctrl_q), 16'h0);
        chk("R4 mask", 16'(mask_q), 16'h0);
        chk("R4 tmp", 16'(tmp_addr), 16'h0);
        chk("R4 finex", 16'(fine_x), 16'h0);
        chk("R4 phase", 16'(wr_second), 16'h0);
        chk("R4 cur", 16'(vram_addr), 16'h0);
    endtask

    task automatic t_warm_open;
        cpu_write(3'd3, 8'h40);
        chk("R5 optr load", 16'(obj_addr), 16'h40);
        cpu_write(3'd4, 8'h99);
        chk("R5 obj_we", 16'(seen_obj_we), 16'h1);
        chk("R5 optr inc", 16'(obj_addr), 16'h41);
        stat_flags = 3'b101;
        cpu_read(3'd2, rval);
        chk("R8 status", 16'(rval), 16'hA0);
        obj_rdata = 8'h3C;
        cpu_read(3'd4, rval);
        chk("R5 obj read", 16'(rval), 16'h3C);
        cpu_write(3'd7, 8'h55);
        chk("R5 vram_we", 16'(seen_vram_we), 16'h1);
        chk("R10 step1", 16'(vram_addr), 16'h1);
        vram_rdata = 8'h5A;
        cpu_read(3'd7, rval);
        chk("R9 warm read1", 16'(rval), 16'h0);
        cpu_read(3'd7, rval);
        chk("R9 warm read2", 16'(rval), 16'h0);
        chk("R10 cur", 16'(vram_addr), 16'h3);
    endtask

    task automatic t_release;
        @(negedge clk);
        vbl_end = 1'b1;
        cpu_sel = 1'b1; cpu_we = 1'b1; cpu_addr = 3'd0; cpu_wdata = 8'h80;
        @(negedge clk);
        vbl_end = 1'b0; cpu_sel = 1'b0; cpu_we = 1'b0;
        chk("R3 same-cycle write", 16'(ctrl_q), 16'h0);
        chk("R3 released", 16'(warming), 16'h0);
        repeat (3) @(negedge clk);
        chk("R3 stays", 16'(warming), 16'h0);
    endtask

    task automatic t_ctrl_mask;
        cpu_write(3'd0, 8'h03);
        chk("R11 ctrl", 16'(ctrl_q), 16'h03);
        chk("R11 tmp", 16'(tmp_addr), 16'h0C00);
        cpu_write(3'd1, 8'h1E);
        chk("R11 mask", 16'(mask_q), 16'h1E);
    endtask

    task automatic t_scroll;
        cpu_write(3'd5, 8'hAD);
        chk("R6 finex", 16'(fine_x), 16'h5);
        chk("R6 tmp first", 16'(tmp_addr), 16'h0C15);
        chk("R6 phase", 16'(wr_second), 16'h1);
        cpu_write(3'd5, 8'h63);
        chk("R6 tmp second", 16'(tmp_addr), 16'h3D95);
        chk("R6 phase back", 16'(wr_second), 16'h0);
    endtask

    task automatic t_addr;
        cpu_write(3'd6, 8'hFF);
        chk("R7 tmp first", 16'(tmp_addr), 16'h3F95);
        chk("R7 cur held", 16'(vram_addr), 16'h3);
        cpu_write(3'd6, 8'hC4);
        chk("R7 tmp second", 16'(tmp_addr), 16'h3FC4);
        chk("R7 cur load", 16'(vram_addr), 16'h3FC4);
    endtask

    task automatic t_status_toggle;
        cpu_write(3'd6, 8'h01);
        chk("R8 pre phase", 16'(wr_second), 16'h1);
        cpu_read(3'd2, rval);
        chk("R8 phase clr", 16'(wr_second), 16'h0);
        cpu_write(3'd6, 8'h12);
        chk("R8 first again", 16'(tmp_addr), 16'h12C4);
        cpu_write(3'd6, 8'h00);
        chk("R7 cur", 16'(vram_addr), 16'h1200);
    endtask

    task automatic t_increment;
        cpu_write(3'd0, 8'h04);
        cpu_write(3'd7, 8'hAB);
        chk("R10 step32 w", 16'(vram_addr), 16'h1220);
        cpu_read(3'd7, rval);
        chk("R9 first live", 16'(rval), 16'h0);
        chk("R10 step32 r", 16'(vram_addr), 16'h1240);
        cpu_write(3'd0, 8'h00);
        cpu_write(3'd7, 8'hAB);
        chk("R10 step1 live", 16'(vram_addr), 16'h1241);
    endtask

    task automatic t_buffer;
        vram_rdata = 8'h11;
        cpu_read(3'd7, rval);
        chk("R9 delayed a", 16'(rval), 16'h5A);
        vram_rdata = 8'h22;
        cpu_read(3'd7, rval);
        chk("R9 delayed b", 16'(rval), 16'h11);
        chk("R10 cur", 16'(vram_addr), 16'h1243);
    endtask

    task automatic t_reset;
        cpu_write(3'd0, 8'h81);
        cpu_write(3'd1, 8'h18);
        cpu_write(3'd5, 8'h0F);
        cpu_write(3'd3, 8'h7E);
        chk("R2 pre phase", 16'(wr_second), 16'h1);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk("R2 ctrl", 16'(ctrl_q), 16'h0);
        chk("R2 mask", 16'(mask_q), 16'h0);
        chk("R2 tmp", 16'(tmp_addr), 16'h0);
        chk("R2 finex", 16'(fine_x), 16'h0);
        chk("R2 phase", 16'(wr_second), 16'h0);
        chk("R2 warming", 16'(warming), 16'h1);
        chk("R2 cur kept", 16'(vram_addr), 16'h1243);
        chk("R2 optr kept", 16'(obj_addr), 16'h7E);
        cpu_read(3'd7, rval);
        chk("R2 buffer clr", 16'(rval), 16'h0);
        cpu_write(3'd0, 8'h80);
        chk("R4 relock", 16'(ctrl_q), 16'h0);
    endtask

    task automatic t_power_again;
        @(negedge clk); por_n = 1'b0;
        repeat (2) @(negedge clk);
        por_n = 1'b1;
        chk("R1 cur clr", 16'(vram_addr), 16'h0);
        chk("R1 optr clr", 16'(obj_addr), 16'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        t_power_on();
        t_warm_blocked();
        t_warm_open();
        t_release();
        t_ctrl_mask();
        t_scroll();
        t_addr();
        t_status_toggle();
        t_increment();
        t_buffer();
        t_reset();
        t_power_again();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule